// File: doc/BRIEF.md
# Multi-Thread In-Order Retire Controller

This block sits at the back end of an out-of-order core and decides, every cycle, which instructions leave the reorder buffer. It sees a small window of head entries for each of up to four hardware threads (valid, completed, non-speculative, squash-after, fault and sequence number per slot) together with each thread's occupancy. It does not hold the entries itself; it reports how many head entries of one chosen thread retire this cycle, which non-speculative head may now issue, and when and where each thread's buffer must be flushed.

Each thread runs its own status machine with six states: `S_IDLE` (buffer empty), `S_RUNNING` (normal retirement), `S_TRAPWAIT` (a faulting head is waiting out the trap delay), `S_TRAPREDIR` (one cycle in which the trap flush is requested), `S_SQAFTER` (the cycle after a squash-after instruction retired, in which the flush of everything younger is requested) and `S_DRAINSQ` (the buffer is being emptied a bounded number of entries per cycle). Transitions: IDLE to RUNNING when a valid head appears; RUNNING to IDLE when the head is empty; RUNNING to TRAPWAIT on a faulting head; RUNNING to SQAFTER when the retired group ends on a squash-after instruction; TRAPWAIT to TRAPREDIR when the delay has elapsed; TRAPREDIR and SQAFTER to DRAINSQ; DRAINSQ to IDLE when the last entries are removed.

A selector picks the thread served each cycle under one of three policies: fixed priority, rotating, or oldest head first. Non-speculative heads are released one per cycle.

Top module: `retire_ctrl`

## Requirements
- R1: Retirement from the served thread counts the leading head slots that are valid, completed and fault-free, stops at the first slot that is not, and never exceeds the window width; only a thread in Running retires.
- R2: With policy code 0 the served thread is the lowest-numbered active thread in Running whose slot 0 is valid, completed and fault-free.
- R3: With policy code 1 the served thread is the first ready active thread at or after a rotating pointer (cleared by reset); after each service the pointer moves to the thread after the one served.
- R4: With policy code 2 the served thread is the ready active thread whose slot-0 sequence number is smallest, ties going to the lower thread number.
- R5: A thread in Running whose slot 0 is valid, non-speculative, not completed and fault-free gets its slot-0 sequence number broadcast once; at most one thread is released per cycle (lowest number first), and a thread may be released again only after it has retired.
- R6: A retired squash-after instruction is the last of its group; in the following cycle the thread raises its squash request with that instruction's sequence number and the inclusive flag at 0, then enters draining.
- R7: In the request cycle the thread's occupancy is captured; each following draining cycle removes min(cap, remaining) entries, and after the cycle that removes the last of them the thread is Idle.
- R8: A faulting slot 0 in Running retires nothing, holds the thread for the trap delay in cycles, then raises the squash request with the fault's sequence number and the inclusive flag at 1 for one cycle, then drains.
- R9: A thread in Running whose slot 0 is empty becomes Idle on the next cycle; an Idle thread retires nothing and becomes Running one cycle after slot 0 turns valid.
- R10: A thread's change flag is high in exactly the cycles in which it retires at least one entry or drops at least one entry.
- R11: After reset every thread is Idle and every output is zero.
- R12: A thread whose active bit is 0 is neither served nor released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy | input | 2 | Thread selection policy: 0 fixed, 1 rotating, 2 oldest |
| active | input | NT | Per-thread active bits |
| head_valid | input | NT*W | Slot valid, thread t slot i at bit t*W+i |
| head_done | input | NT*W | Slot completed |
| head_nonspec | input | NT*W | Slot is non-speculative |
| head_sqafter | input | NT*W | Slot requests squash of younger work |
| head_fault | input | NT*W | Slot carries a fault |
| head_seq | input | NT*W*SEQW | Slot sequence numbers |
| occupancy | input | NT*OCCW | Per-thread buffer entry count |
| retire_cnt | output | clog2(W+1) | Entries retired this cycle |
| retire_tid | output | clog2(NT) | Thread served this cycle |
| nsrel_valid | output | 1 | Non-speculative release strobe |
| nsrel_tid | output | clog2(NT) | Released thread |
| nsrel_seq | output | SEQW | Released sequence number |
| squash_valid | output | NT | Per-thread squash request |
| squash_incl | output | NT | 1 if the target entry itself is flushed |
| squash_seq | output | NT*SEQW | Per-thread squash target |
| drop_cnt | output | NT*clog2(CAP+1) | Entries removed this cycle per thread |
| rob_changed | output | NT | Per-thread entry-count changed flag |

## Verification
The hardest situation to reach is the squash-after sequence landing at each position of the head window while the drain takes different numbers of cycles. The stimulus first parks the thread in Running with a non-completed head, then presents a window whose squash-after bit walks across every slot, with an occupancy chosen per position so that drains of one, two and three cycles occur, and follows the thread through draining back to Idle and Running.

// File: rtl/retire_pkg.sv
package retire_pkg;

    typedef enum logic [2:0] {
        S_IDLE      = 3'd0,
        S_RUNNING   = 3'd1,
        S_DRAINSQ   = 3'd2,
        S_TRAPWAIT  = 3'd3,
        S_TRAPREDIR = 3'd4,
        S_SQAFTER   = 3'd5
    } tstate_e;

    typedef enum logic [1:0] {
        POL_FIXED  = 2'd0,
        POL_ROTATE = 2'd1,
        POL_OLDEST = 2'd2,
        POL_RSVD   = 2'd3
    } policy_e;

endpackage

// File: rtl/rt_head_scan.sv
module rt_head_scan #(
    parameter int W    = 4,
    parameter int SEQW = 16,
    localparam int CW  = $clog2(W + 1)
) (
    input  logic [W-1:0]      v,
    input  logic [W-1:0]      d,
    input  logic [W-1:0]      f,
    input  logic [W-1:0]      sqa,
    input  logic [W*SEQW-1:0] seq,
    output logic              ready,
    output logic [CW-1:0]     cnt,
    output logic              hit,
    output logic [SEQW-1:0]   hit_seq
);
    logic stop;

    always_comb begin
        cnt     = '0;
        hit     = 1'b0;
        hit_seq = '0;
        stop    = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (!stop) begin
                if (v[i] && d[i] && !f[i]) begin
                    cnt = cnt + CW'(1);
                    if (sqa[i]) begin
                        hit     = 1'b1;
                        hit_seq = seq[i*SEQW +: SEQW];
                        stop    = 1'b1;
                    end
                end else begin
                    stop = 1'b1;
                end
            end
        end
        ready = v[0] && d[0] && !f[0];
    end
endmodule

// File: rtl/rt_select.sv
module rt_select
    import retire_pkg::*;
#(
    parameter int NT   = 4,
    parameter int SEQW = 16,
    localparam int TW  = $clog2(NT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        policy,
    input  logic [NT-1:0]     cand,
    input  logic [NT*SEQW-1:0] seq0,
    output logic              pick_valid,
    output logic [TW-1:0]     pick_tid
);
    logic [TW-1:0]   ptr_q;
    logic [SEQW-1:0] best;
    int              idx;

    always_comb begin
        pick_valid = 1'b0;
        pick_tid   = '0;
        best       = '0;
        idx        = 0;
        unique case (policy_e'(policy))
            POL_ROTATE: begin
                for (int k = 0; k < NT; k++) begin
                    idx = int'(ptr_q) + k;
                    if (idx >= NT) idx = idx - NT;
                    if (!pick_valid && cand[idx]) begin
                        pick_valid = 1'b1;
                        pick_tid   = TW'(idx);
                    end
                end
            end
            POL_OLDEST: begin
                for (int t = 0; t < NT; t++) begin
                    if (cand[t] && (!pick_valid || seq0[t*SEQW +: SEQW] < best)) begin
                        pick_valid = 1'b1;
                        pick_tid   = TW'(t);
                        best       = seq0[t*SEQW +: SEQW];
                    end
                end
            end
            POL_FIXED, POL_RSVD: begin
                for (int t = NT - 1; t >= 0; t--) begin
                    if (cand[t]) begin
                        pick_valid = 1'b1;
                        pick_tid   = TW'(t);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (policy_e'(policy) == POL_ROTATE && pick_valid) begin
            ptr_q <= (int'(pick_tid) == NT - 1) ? '0 : pick_tid + TW'(1);
        end
    end

    // R2
    pick_is_candidate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid |-> cand[pick_tid]);

    // R3
    rotate_ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (policy_e'(policy) == POL_ROTATE && pick_valid && int'(pick_tid) != NT - 1)
        |=> ptr_q == $past(pick_tid) + TW'(1));
endmodule

// File: rtl/rt_thread_fsm.sv
module rt_thread_fsm
    import retire_pkg::*;
#(
    parameter int SEQW     = 16,
    parameter int OCCW     = 6,
    parameter int SQ_CAP   = 3,
    parameter int TRAP_LAT = 3,
    localparam int DW      = $clog2(SQ_CAP + 1),
    localparam int TCW     = $clog2(TRAP_LAT + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            s0_valid,
    input  logic            s0_done,
    input  logic            s0_fault,
    input  logic            s0_nonspec,
    input  logic [SEQW-1:0] s0_seq,
    input  logic            served,
    input  logic            sqa_hit,
    input  logic [SEQW-1:0] sqa_seq,
    input  logic            ns_grant,
    input  logic [OCCW-1:0] occ,
    output logic            running,
    output logic            ns_want,
    output logic            sq_valid,
    output logic            sq_incl,
    output logic [SEQW-1:0] sq_seq,
    output logic [DW-1:0]   drop
);
    localparam logic [OCCW-1:0] CAPV = OCCW'(SQ_CAP);

    tstate_e         st_q, st_d;
    logic [TCW-1:0]  cnt_q, cnt_d;
    logic [OCCW-1:0] rem_q, rem_d;
    logic [SEQW-1:0] tgt_q, tgt_d;
    logic            rel_q, rel_d;
    logic [OCCW-1:0] drop_w;

    assign drop_w = (rem_q > CAPV) ? CAPV : rem_q;

    // next-state logic
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        rem_d = rem_q;
        tgt_d = tgt_q;
        rel_d = rel_q;
        unique case (st_q)
            S_IDLE: begin
                if (s0_valid) st_d = S_RUNNING;
            end
            S_RUNNING: begin
                if (ns_grant) rel_d = 1'b1;
                if (served)   rel_d = 1'b0;
                if (!s0_valid) begin
                    st_d = S_IDLE;
                end else if (s0_fault) begin
                    st_d  = S_TRAPWAIT;
                    cnt_d = TCW'(TRAP_LAT - 1);
                    tgt_d = s0_seq;
                end else if (served && sqa_hit) begin
                    st_d  = S_SQAFTER;
                    tgt_d = sqa_seq;
                end
            end
            S_TRAPWAIT: begin
                if (cnt_q == '0) st_d = S_TRAPREDIR;
                else             cnt_d = cnt_q - TCW'(1);
            end
            S_TRAPREDIR, S_SQAFTER: begin
                rem_d = occ;
                st_d  = S_DRAINSQ;
            end
            S_DRAINSQ: begin
                rem_d = rem_q - drop_w;
                if (rem_q <= CAPV) st_d = S_IDLE;
            end
            default: st_d = S_IDLE;
        endcase
        if (st_d != S_RUNNING) rel_d = 1'b0;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= S_IDLE;
            cnt_q <= '0;
            rem_q <= '0;
            tgt_q <= '0;
            rel_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            rem_q <= rem_d;
            tgt_q <= tgt_d;
            rel_q <= rel_d;
        end
    end

    // outputs
    always_comb begin
        running  = (st_q == S_RUNNING);
        ns_want  = 1'b0;
        sq_valid = 1'b0;
        sq_incl  = 1'b0;
        sq_seq   = '0;
        drop     = '0;
        unique case (st_q)
            S_RUNNING:   ns_want = s0_valid && s0_nonspec && !s0_done && !s0_fault && !rel_q;
            S_TRAPREDIR: begin
                sq_valid = 1'b1;
                sq_incl  = 1'b1;
                sq_seq   = tgt_q;
            end
            S_SQAFTER: begin
                sq_valid = 1'b1;
                sq_seq   = tgt_q;
            end
            S_DRAINSQ:   drop = DW'(drop_w);
            default: ;
        endcase
    end

    // R6
    sqafter_from_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == S_SQAFTER |-> $past(st_q) == S_RUNNING && $past(served) && $past(sqa_hit));

    // R8
    trapredir_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == S_TRAPREDIR |-> $past(st_q) == S_TRAPWAIT);

    // R7
    drop_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(drop) <= SQ_CAP);

    // R7
    drain_ends_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_DRAINSQ && rem_q <= CAPV) |=> st_q == S_IDLE);

    // R5
    release_flag_from_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rel_q) |-> $past(ns_grant));
endmodule

// File: rtl/retire_ctrl.sv
module retire_ctrl
    import retire_pkg::*;
#(
    parameter int NT       = 4,
    parameter int W        = 4,
    parameter int SEQW     = 16,
    parameter int OCCW     = 6,
    parameter int SQ_CAP   = 3,
    parameter int TRAP_LAT = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [1:0]                        policy,
    input  logic [NT-1:0]                     active,
    input  logic [NT*W-1:0]                   head_valid,
    input  logic [NT*W-1:0]                   head_done,
    input  logic [NT*W-1:0]                   head_nonspec,
    input  logic [NT*W-1:0]                   head_sqafter,
    input  logic [NT*W-1:0]                   head_fault,
    input  logic [NT*W*SEQW-1:0]              head_seq,
    input  logic [NT*OCCW-1:0]                occupancy,
    output logic [$clog2(W+1)-1:0]            retire_cnt,
    output logic [$clog2(NT)-1:0]             retire_tid,
    output logic                              nsrel_valid,
    output logic [$clog2(NT)-1:0]             nsrel_tid,
    output logic [SEQW-1:0]                   nsrel_seq,
    output logic [NT-1:0]                     squash_valid,
    output logic [NT-1:0]                     squash_incl,
    output logic [NT*SEQW-1:0]                squash_seq,
    output logic [NT*$clog2(SQ_CAP+1)-1:0]    drop_cnt,
    output logic [NT-1:0]                     rob_changed
);
    localparam int CW = $clog2(W + 1);
    localparam int TW = $clog2(NT);
    localparam int DW = $clog2(SQ_CAP + 1);

    logic [NT-1:0]      ready, running, hit, ns_want, ns_grant, cand, served;
    logic [CW-1:0]      cnt   [NT];
    logic [SEQW-1:0]    hseq  [NT];
    logic [NT*SEQW-1:0] seq0;
    logic               pick_valid;
    logic [TW-1:0]      pick_tid;

    for (genvar t = 0; t < NT; t++) begin : g_thr
        assign seq0[t*SEQW +: SEQW] = head_seq[t*W*SEQW +: SEQW];

        rt_head_scan #(.W(W), .SEQW(SEQW)) u_scan (
            .v       (head_valid  [t*W +: W]),
            .d       (head_done   [t*W +: W]),
            .f       (head_fault  [t*W +: W]),
            .sqa     (head_sqafter[t*W +: W]),
            .seq     (head_seq[t*W*SEQW +: W*SEQW]),
            .ready   (ready[t]),
            .cnt     (cnt[t]),
            .hit     (hit[t]),
            .hit_seq (hseq[t])
        );

        rt_thread_fsm #(
            .SEQW(SEQW), .OCCW(OCCW), .SQ_CAP(SQ_CAP), .TRAP_LAT(TRAP_LAT)
        ) u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .s0_valid   (head_valid[t*W]),
            .s0_done    (head_done[t*W]),
            .s0_fault   (head_fault[t*W]),
            .s0_nonspec (head_nonspec[t*W]),
            .s0_seq     (head_seq[t*W*SEQW +: SEQW]),
            .served     (served[t]),
            .sqa_hit    (hit[t]),
            .sqa_seq    (hseq[t]),
            .ns_grant   (ns_grant[t]),
            .occ        (occupancy[t*OCCW +: OCCW]),
            .running    (running[t]),
            .ns_want    (ns_want[t]),
            .sq_valid   (squash_valid[t]),
            .sq_incl    (squash_incl[t]),
            .sq_seq     (squash_seq[t*SEQW +: SEQW]),
            .drop       (drop_cnt[t*DW +: DW])
        );

        assign cand[t]        = active[t] && running[t] && ready[t];
        assign served[t]      = pick_valid && (int'(pick_tid) == t);
        assign rob_changed[t] = served[t] || (drop_cnt[t*DW +: DW] != '0);
    end

    rt_select #(.NT(NT), .SEQW(SEQW)) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .policy     (policy),
        .cand       (cand),
        .seq0       (seq0),
        .pick_valid (pick_valid),
        .pick_tid   (pick_tid)
    );

    assign retire_cnt = pick_valid ? cnt[pick_tid] : '0;
    assign retire_tid = pick_valid ? pick_tid : '0;

    // one non-speculative release per cycle, lowest thread first
    always_comb begin
        ns_grant    = '0;
        nsrel_valid = 1'b0;
        nsrel_tid   = '0;
        nsrel_seq   = '0;
        for (int t = 0; t < NT; t++) begin
            if (!nsrel_valid && ns_want[t] && active[t]) begin
                nsrel_valid = 1'b1;
                nsrel_tid   = TW'(t);
                nsrel_seq   = seq0[t*SEQW +: SEQW];
                ns_grant[t] = 1'b1;
            end
        end
    end

    // R1
    retire_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(retire_cnt) <= W);

    // R1
    retire_head_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retire_cnt != '0 |-> head_valid[int'(retire_tid)*W] && head_done[int'(retire_tid)*W]);

    // R5
    single_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ns_grant));

    // R12
    release_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nsrel_valid |-> active[nsrel_tid]);
endmodule

// File: tb/sim_retire_ctrl.sv
`timescale 1ns/1ps
module sim_retire_ctrl;
    localparam int NT = 4, W = 4, SEQW = 16, OCCW = 6, CAP = 3, TLAT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [1:0]            policy = '0;
    logic [NT-1:0]         active = '0;
    logic [NT*W-1:0]       hv = '0, hd = '0, hn = '0, hs = '0, hf = '0;
    logic [NT*W*SEQW-1:0]  hq = '0;
    logic [NT*OCCW-1:0]    occ = '0;
    logic [2:0]            retire_cnt;
    logic [1:0]            retire_tid, nsrel_tid;
    logic                  nsrel_valid;
    logic [SEQW-1:0]       nsrel_seq;
    logic [NT-1:0]         squash_valid, squash_incl, rob_changed;
    logic [NT*SEQW-1:0]    squash_seq;
    logic [NT*2-1:0]       drop_cnt;

    retire_ctrl #(.NT(NT), .W(W), .SEQW(SEQW), .OCCW(OCCW), .SQ_CAP(CAP), .TRAP_LAT(TLAT)) u0 (
        .clk(clk), .rst_n(rst_n), .policy(policy), .active(active),
        .head_valid(hv), .head_done(hd), .head_nonspec(hn), .head_sqafter(hs),
        .head_fault(hf), .head_seq(hq), .occupancy(occ),
        .retire_cnt(retire_cnt), .retire_tid(retire_tid),
        .nsrel_valid(nsrel_valid), .nsrel_tid(nsrel_tid), .nsrel_seq(nsrel_seq),
        .squash_valid(squash_valid), .squash_incl(squash_incl), .squash_seq(squash_seq),
        .drop_cnt(drop_cnt), .rob_changed(rob_changed)
    );

    int nchk = 0, nerr = 0;
    bit done_flag = 0;

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic setslot(input int t, input int i, input bit v, input bit d,
                           input bit n, input bit s, input bit f, input int sq);
        hv[t*W+i] = v; hd[t*W+i] = d; hn[t*W+i] = n; hs[t*W+i] = s; hf[t*W+i] = f;
        hq[(t*W+i)*SEQW +: SEQW] = SEQW'(sq);
    endtask

    task automatic clrthr(input int t);
        for (int i = 0; i < W; i++) setslot(t, i, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic adv;
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        nerr++;
        $display("FAIL watchdog expired");
        if (!done_flag) begin
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        int exp, rem, ptr, pick, best, ec;
        bit last, stop;
        logic [3:0] vv, dd, ff;

        repeat (3) adv;
        #1;
        // R11: reset state
        check("R11 retire_cnt", retire_cnt, 0);
        check("R11 squash_valid", squash_valid, 0);
        check("R11 rob_changed", rob_changed, 0);
        check("R11 nsrel_valid", nsrel_valid, 0);
        check("R11 drop_cnt", drop_cnt, 0);
        adv;
        rst_n = 1'b1;
        active = 4'b0001;

        // R9 / R11: idle after reset, running one cycle later
        setslot(0, 0, 1, 1, 0, 0, 0, 1);
        #1 check("R9 idle retires nothing", retire_cnt, 0);
        adv;
        #1 check("R9 running after valid head", retire_cnt, 1);
        adv;
        clrthr(0);
        #1 check("R9 empty head", retire_cnt, 0);
        adv;
        setslot(0, 0, 1, 1, 0, 0, 0, 2);
        #1 check("R9 idle after empty head", retire_cnt, 0);
        adv;

        // R1 / R10: sweep of valid and done patterns over the window
        for (int p = 0; p < 256; p++) begin
            clrthr(0);
            setslot(0, 0, 1, 0, 0, 0, 0, 3);
            #1; adv;
            vv = 4'(p); dd = 4'(p >> 4);
            ff = (p % 3 == 0) ? 4'b0100 : 4'b0000;
            for (int i = 0; i < W; i++) setslot(0, i, vv[i], dd[i], 0, 0, ff[i], 4 + i);
            exp = 0; stop = 0;
            for (int i = 0; i < W; i++)
                if (!stop) begin
                    if (vv[i] && dd[i] && !ff[i]) exp++; else stop = 1;
                end
            #1;
            check("R1 prefix count", retire_cnt, exp);
            check("R10 change flag on retire", rob_changed[0], (exp > 0) ? 1 : 0);
            adv;
        end

        // R6 / R7: squash-after at each window position
        for (int pos = 0; pos < W; pos++) begin
            clrthr(0);
            setslot(0, 0, 1, 0, 0, 0, 0, 9);
            #1; adv;
            for (int i = 0; i < W; i++) setslot(0, i, 1, 1, 0, (i == pos), 0, 10 + i);
            #1 check("R6 group ends at squash-after", retire_cnt, pos + 1);
            adv;
            occ[0 +: OCCW] = 6'(pos * 2 + 1);
            #1;
            check("R6 squash request", squash_valid[0], 1);
            check("R6 squash not inclusive", squash_incl[0], 0);
            check("R6 squash target", squash_seq[0 +: SEQW], 10 + pos);
            check("R6 no retire while pending", retire_cnt, 0);
            adv;
            rem = pos * 2 + 1;
            for (int c = 0; c < 8; c++) begin
                ec = (rem > CAP) ? CAP : rem;
                last = (rem <= CAP);
                #1;
                check("R7 drop count", drop_cnt[1:0], ec);
                check("R10 change flag on drop", rob_changed[0], (ec > 0) ? 1 : 0);
                check("R7 no retire while draining", retire_cnt, 0);
                rem -= ec;
                adv;
                if (last) break;
            end
            for (int i = 0; i < W; i++) setslot(0, i, 1, 1, 0, 0, 0, 20 + i);
            #1;
            check("R7 idle after drain", retire_cnt, 0);
            check("R7 drain finished", drop_cnt[1:0], 0);
            adv;
        end

        // R8: trap delay then inclusive squash
        clrthr(0);
        setslot(0, 0, 1, 0, 0, 0, 0, 29);
        #1; adv;
        setslot(0, 0, 1, 1, 0, 0, 1, 30);
        setslot(0, 1, 1, 1, 0, 0, 0, 31);
        #1 check("R8 faulting head retires nothing", retire_cnt, 0);
        adv;
        for (int c = 0; c < TLAT; c++) begin
            #1 check("R8 waiting out trap delay", squash_valid[0], 0);
            adv;
        end
        clrthr(0);
        occ[0 +: OCCW] = 6'd2;
        #1;
        check("R8 trap squash request", squash_valid[0], 1);
        check("R8 trap squash inclusive", squash_incl[0], 1);
        check("R8 trap squash target", squash_seq[0 +: SEQW], 30);
        adv;
        #1 check("R8 trap drain", drop_cnt[1:0], 2);
        adv;
        #1 check("R8 back to idle", drop_cnt[1:0], 0);
        adv;

        // R2 / R3 / R4: selection sweep over all four threads
        active = 4'b1111;
        for (int t = 0; t < NT; t++) begin
            clrthr(t);
            setslot(t, 0, 1, 0, 0, 0, 0, 0);
        end
        #1; adv;
        ptr = 0;
        for (int pol = 0; pol < 3; pol++) begin
            policy = 2'(pol);
            for (int m = 0; m < 16; m++) begin
                for (int t = 0; t < NT; t++)
                    setslot(t, 0, 1, m[t], 0, 0, 0, (m * 5 + t * 3) % 8);
                pick = -1; best = 0;
                if (pol == 0) begin
                    for (int t = NT - 1; t >= 0; t--) if (m[t]) pick = t;
                end else if (pol == 1) begin
                    for (int k = 0; k < NT; k++)
                        if (pick < 0 && m[(ptr + k) % NT]) pick = (ptr + k) % NT;
                    if (pick >= 0) ptr = (pick + 1) % NT;
                end else begin
                    for (int t = 0; t < NT; t++)
                        if (m[t] && (pick < 0 || (m * 5 + t * 3) % 8 < best)) begin
                            pick = t; best = (m * 5 + t * 3) % 8;
                        end
                end
                #1;
                check(pol == 0 ? "R2 served count" : pol == 1 ? "R3 served count" : "R4 served count",
                      retire_cnt, (pick >= 0) ? 1 : 0);
                if (pick >= 0)
                    check(pol == 0 ? "R2 served thread" : pol == 1 ? "R3 served thread" : "R4 served thread",
                          retire_tid, pick);
                check("R10 change flags", rob_changed, (pick >= 0) ? (1 << pick) : 0);
                adv;
            end
        end

        // R12: inactive threads are skipped
        policy = 2'd0;
        active = 4'b1010;
        for (int t = 0; t < NT; t++) setslot(t, 0, 1, 1, 0, 0, 0, 60 + t);
        #1;
        check("R12 inactive thread not served", retire_tid, 1);
        check("R12 served count", retire_cnt, 1);
        adv;
        for (int t = 0; t < NT; t++) setslot(t, 0, 1, 0, (t == 0), 0, 0, 64 + t);
        #1;
        check("R12 inactive thread not released", nsrel_valid, 0);
        adv;

        // R5: non-speculative release, one per cycle, once per head
        active = 4'b1111;
        for (int t = 0; t < NT; t++) setslot(t, 0, 1, 0, 0, 0, 0, 70 + t);
        setslot(1, 0, 1, 0, 1, 0, 0, 40);
        setslot(2, 0, 1, 0, 1, 0, 0, 50);
        #1;
        check("R5 first release valid", nsrel_valid, 1);
        check("R5 first release thread", nsrel_tid, 1);
        check("R5 first release seq", nsrel_seq, 40);
        adv;
        #1;
        check("R5 second release thread", nsrel_tid, 2);
        check("R5 second release seq", nsrel_seq, 50);
        adv;
        #1 check("R5 no repeat release", nsrel_valid, 0);
        adv;
        setslot(1, 0, 1, 1, 1, 0, 0, 40);
        #1;
        check("R5 released head retires", retire_tid, 1);
        check("R5 no release on retire", nsrel_valid, 0);
        adv;
        setslot(1, 0, 1, 0, 1, 0, 0, 41);
        #1;
        check("R5 new head released", nsrel_tid, 1);
        check("R5 new head seq", nsrel_seq, 41);
        adv;

        done_flag = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule